// File: doc/BRIEF.md
# Three-Requester Memory Access Arbiter

This block decides which of three requesters may use a shared SDRAM controller. The three requesters are a CPU port, an internal refresh source and a bus-master port that moves data in long bursts. A one-bit policy register chooses between two arbitration policies.

- **Fixed priority:** the CPU wins over refresh, and refresh wins over the burst port. A pending refresh may cut into a running burst at any word. The CPU may cut in only when the burst's word count reaches a 16-word or 32-word boundary. After the inserted operation completes, the grant goes straight back to the suspended burst. The burst's word count is kept.
- **Arrival order:** requests are served in the order they are raised. Requests raised in the same cycle are queued CPU first, then refresh, then the burst port. No grant is ever taken away.

A 16-bit down-counting refresh timer raises the refresh request each time it expires. It then reloads itself. Its value can be read as a 32-bit word. Grants are registered and one-hot. A grant stays asserted until its owner pulses done, except when the fixed-priority preemption described above takes it away.

Top module: `mem_arb`

## Requirements
- R1: While reset is held and in the first cycle after it, all grants and `ref_req` are 0, `timer_rd` reads 0x00000200 and the policy is fixed priority.
- R2: The timer value falls by one every cycle. In the cycle after it reads 0, it reads 0x0200 again and `ref_req` goes to 1. `ref_req` stays 1 until a done pulse arrives on `ref_done` while `gnt_ref` is high.
- R3: Bits 31:16 of `timer_rd` are always 0.
- R4: At most one grant is high in any cycle. `gnt_cpu` and `gnt_ref` stay high until the matching done pulse. `gnt_ibus` falls without `ibus_done` only when the grant passes directly to the CPU or to refresh.
- R5: With the policy at 0 and no owner, the grant goes to the winner among CPU, refresh and burst port, in that order, in the cycle after the request. A done pulse leaves one cycle with no grant before the next new owner.
- R6: With the policy at 0, the CPU takes the grant from a running burst only in the cycle after the burst's beat count reaches a nonzero multiple of 16 (`bnd_sel`=0) or of 32 (`bnd_sel`=1). Beats are `ibus_beat` cycles that fall while `gnt_ibus` is high. The count restarts at 0 for each new burst.
- R7: With the policy at 0, a pending refresh takes the grant from a running burst in the cycle after `ref_req` is seen, whatever the beat count.
- R8: When an inserted CPU or refresh operation pulses done, `gnt_ibus` returns in the next cycle. The beat count continues from where it stopped.
- R9: A cycle with `pol_we`=1 loads `pol_wd` into the policy bit. 0 selects fixed priority and 1 selects arrival order.
- R10: With the policy at 1, requests are granted in arrival order. An idle arbiter grants a new request two cycles after it is first raised. A burst is never preempted.
- R11: With the policy at 1, requests from CPU, refresh and burst port that arrive in the same cycle are served CPU, then refresh, then burst port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pol_we | input | 1 | Policy register write enable |
| pol_wd | input | 1 | Policy value to write (0 fixed, 1 arrival order) |
| bnd_sel | input | 1 | CPU cut-in boundary: 0 every 16 words, 1 every 32 words |
| cpu_req | input | 1 | CPU access request |
| cpu_done | input | 1 | CPU access complete pulse |
| ibus_req | input | 1 | Burst port request |
| ibus_beat | input | 1 | One data word of the granted burst moved |
| ibus_done | input | 1 | Burst complete pulse |
| ref_done | input | 1 | Refresh operation complete pulse |
| gnt_cpu | output | 1 | Grant to CPU |
| gnt_ref | output | 1 | Grant to refresh |
| gnt_ibus | output | 1 | Grant to burst port |
| ref_req | output | 1 | Refresh pending |
| timer_rd | output | 32 | Refresh timer value, upper half zero |

## Verification
The bench counts the burst-granted cycles before a waiting CPU takes over, at both boundary settings. A design that cut in one boundary early or late, or that ignored `bnd_sel`, shows a different count. It then counts the cycles again after a resume. A design that restarted the beat count on resume would wait 17 cycles instead of 16. It lines up a refresh expiry with CPU and burst requests raised in the same cycle under arrival order. A wrong tie order or a missing queue would then serve them out of order. It also walks the timer through its expiry. A reload off by one cycle, or a refresh request that clears before it is served, is caught there.

// File: rtl/mem_arb_pkg.sv
package mem_arb_pkg;

    localparam int TIMER_W = 16;
    localparam logic [TIMER_W-1:0] TIMER_RELOAD = 16'h0200;
    localparam int RD_W    = 32;
    localparam int NUM_REQ = 3;
    localparam int BEAT_W  = 8;
    localparam int SEG_LOG = 4;   // narrow boundary = 2**SEG_LOG words, wide = twice that

    // owner encoding; requester index i maps to owner value i+1
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_CPU  = 2'd1,
        OWN_REF  = 2'd2,
        OWN_IBUS = 2'd3
    } owner_e;

    // bit 0 cpu, bit 1 refresh, bit 2 burst port
    typedef logic [NUM_REQ-1:0] req_vec_t;

    typedef struct packed {
        owner_e owner;
        logic   susp;     // a burst is parked behind an inserted operation
    } arb_state_t;

    function automatic owner_e idx_to_owner(input int idx);
        return owner_e'(idx + 1);
    endfunction

    function automatic req_vec_t owner_onehot(input owner_e o);
        req_vec_t v;
        v = '0;
        if (o != OWN_NONE) v[int'(o) - 1] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/mem_arb_refresh_timer.sv
module mem_arb_refresh_timer
    import mem_arb_pkg::*;
#(
    parameter int                W      = TIMER_W,
    parameter logic [W-1:0]      RELOAD = TIMER_RELOAD
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         served,
    output logic [W-1:0] count,
    output logic         pend
);
    logic expired;
    assign expired = (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= RELOAD;
            pend  <= 1'b0;
        end else begin
            count <= expired ? RELOAD : count - 1'b1;
            if (expired)     pend <= 1'b1;
            else if (served) pend <= 1'b0;
        end
    end
endmodule

// File: rtl/mem_arb_beat_counter.sv
module mem_arb_beat_counter
    import mem_arb_pkg::*;
#(
    parameter int W   = BEAT_W,
    parameter int SEG = SEG_LOG
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic beat,
    input  logic wide,
    input  logic mark,
    output logic at_bnd
);
    localparam logic [W-1:0] MASK_N = W'((1 << SEG) - 1);
    localparam logic [W-1:0] MASK_W = W'((1 << (SEG + 1)) - 1);

    logic [W-1:0] cnt;
    logic         used;   // this boundary already gave one cut-in
    logic [W-1:0] mask;

    assign mask   = wide ? MASK_W : MASK_N;
    assign at_bnd = (cnt != '0) && ((cnt & mask) == '0) && !used;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt  <= '0;
            used <= 1'b0;
        end else if (beat) begin
            cnt  <= cnt + 1'b1;
            used <= 1'b0;
        end else if (mark) begin
            used <= 1'b1;
        end
    end
endmodule

// File: rtl/mem_arb_fcfs_queue.sv
module mem_arb_fcfs_queue
    import mem_arb_pkg::*;
#(
    parameter int N = NUM_REQ
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic [N-1:0] arrive,
    input  logic         pop,
    output owner_e       head,
    output logic         head_vld,
    output logic [N-1:0] queued
);
    localparam int CW = $clog2(N + 1);

    owner_e         ent   [N];
    owner_e         ent_n [N];
    logic [CW-1:0]  cnt, cnt_n;

    always_comb begin
        for (int i = 0; i < N; i++) ent_n[i] = ent[i];
        cnt_n = cnt;
        if (pop && cnt != '0) begin
            for (int i = 0; i < N - 1; i++) ent_n[i] = ent[i + 1];
            ent_n[N-1] = OWN_NONE;
            cnt_n      = cnt - 1'b1;
        end
        for (int i = 0; i < N; i++) begin
            if (arrive[i] && cnt_n < CW'(N)) begin
                ent_n[cnt_n] = idx_to_owner(i);
                cnt_n        = cnt_n + 1'b1;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            queued[i] = 1'b0;
            for (int j = 0; j < N; j++)
                if (CW'(j) < cnt && ent[j] == idx_to_owner(i)) queued[i] = 1'b1;
        end
    end

    assign head     = ent[0];
    assign head_vld = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            cnt <= '0;
            for (int i = 0; i < N; i++) ent[i] <= OWN_NONE;
        end else begin
            cnt <= cnt_n;
            for (int i = 0; i < N; i++) ent[i] <= ent_n[i];
        end
    end
endmodule

// File: rtl/mem_arb.sv
module mem_arb
    import mem_arb_pkg::*;
#(
    parameter logic [TIMER_W-1:0] RELOAD = TIMER_RELOAD
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pol_we,
    input  logic            pol_wd,
    input  logic            bnd_sel,
    input  logic            cpu_req,
    input  logic            cpu_done,
    input  logic            ibus_req,
    input  logic            ibus_beat,
    input  logic            ibus_done,
    input  logic            ref_done,
    output logic            gnt_cpu,
    output logic            gnt_ref,
    output logic            gnt_ibus,
    output logic            ref_req,
    output logic [RD_W-1:0] timer_rd
);
    arb_state_t           st_q, st_n;
    logic                 policy_q;
    logic                 at_bnd, beat_clr, mark, pop;
    logic [TIMER_W-1:0]   tcount;
    req_vec_t             gnt_v, arrive, queued;
    owner_e               head;
    logic                 head_vld;

    always_ff @(posedge clk) begin
        if (rst)         policy_q <= 1'b0;
        else if (pol_we) policy_q <= pol_wd;
    end

    assign gnt_v    = owner_onehot(st_q.owner);
    assign gnt_cpu  = gnt_v[0];
    assign gnt_ref  = gnt_v[1];
    assign gnt_ibus = gnt_v[2];

    mem_arb_refresh_timer #(.W(TIMER_W), .RELOAD(RELOAD)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .served (gnt_ref && ref_done),
        .count  (tcount),
        .pend   (ref_req)
    );
    assign timer_rd = {{(RD_W - TIMER_W){1'b0}}, tcount};

    mem_arb_beat_counter #(.W(BEAT_W), .SEG(SEG_LOG)) u_beats (
        .clk    (clk),
        .rst    (rst),
        .clear  (beat_clr),
        .beat   (gnt_ibus && ibus_beat),
        .wide   (bnd_sel),
        .mark   (mark),
        .at_bnd (at_bnd)
    );

    assign arrive[0] = policy_q && cpu_req  && !queued[0] && !gnt_cpu;
    assign arrive[1] = policy_q && ref_req  && !queued[1] && !gnt_ref;
    assign arrive[2] = policy_q && ibus_req && !queued[2] && !gnt_ibus;

    mem_arb_fcfs_queue #(.N(NUM_REQ)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .flush    (!policy_q),
        .arrive   (arrive),
        .pop      (pop),
        .head     (head),
        .head_vld (head_vld),
        .queued   (queued)
    );

    always_comb begin
        st_n     = st_q;
        beat_clr = 1'b0;
        mark     = 1'b0;
        pop      = 1'b0;
        unique case (st_q.owner)
            OWN_NONE: begin
                if (policy_q) begin
                    if (head_vld) begin
                        pop        = 1'b1;
                        st_n.owner = head;
                        beat_clr   = (head == OWN_IBUS);
                    end
                end else if (cpu_req) begin
                    st_n.owner = OWN_CPU;
                end else if (ref_req) begin
                    st_n.owner = OWN_REF;
                end else if (st_q.susp) begin
                    st_n.owner = OWN_IBUS;
                    st_n.susp  = 1'b0;
                end else if (ibus_req) begin
                    st_n.owner = OWN_IBUS;
                    beat_clr   = 1'b1;
                end
            end
            OWN_CPU: begin
                if (cpu_done) begin
                    st_n.owner = st_q.susp ? OWN_IBUS : OWN_NONE;
                    st_n.susp  = 1'b0;
                end
            end
            OWN_REF: begin
                if (ref_done) begin
                    st_n.owner = st_q.susp ? OWN_IBUS : OWN_NONE;
                    st_n.susp  = 1'b0;
                end
            end
            OWN_IBUS: begin
                if (ibus_done) begin
                    st_n.owner = OWN_NONE;
                end else if (!policy_q) begin
                    if (ref_req) begin
                        st_n.owner = OWN_REF;
                        st_n.susp  = 1'b1;
                    end else if (cpu_req && at_bnd) begin
                        st_n.owner = OWN_CPU;
                        st_n.susp  = 1'b1;
                        mark       = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{owner: OWN_NONE, susp: 1'b0};
        else     st_q <= st_n;
    end
endmodule

// File: rtl/mem_arb_checker.sv
module mem_arb_checker
    import mem_arb_pkg::*;
#(
    parameter logic [TIMER_W-1:0] RELOAD = TIMER_RELOAD
) (
    input logic            clk,
    input logic            rst,
    input logic            gnt_cpu,
    input logic            gnt_ref,
    input logic            gnt_ibus,
    input logic            cpu_done,
    input logic            ref_done,
    input logic            ibus_done,
    input logic            ref_req,
    input logic [RD_W-1:0] timer_rd,
    input logic            policy_q,
    input logic            at_bnd
);
    assert_onehot_grant_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({gnt_cpu, gnt_ref, gnt_ibus}));

    assert_cpu_hold_R4: assert property (@(posedge clk) disable iff (rst)
        gnt_cpu && !cpu_done |=> gnt_cpu);

    assert_ref_hold_R4: assert property (@(posedge clk) disable iff (rst)
        gnt_ref && !ref_done |=> gnt_ref);

    assert_ibus_handoff_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(gnt_ibus) && !$past(ibus_done) |-> gnt_cpu || gnt_ref);

    assert_timer_step_R2: assert property (@(posedge clk) disable iff (rst)
        timer_rd[TIMER_W-1:0] != '0 |=>
            timer_rd[TIMER_W-1:0] == $past(timer_rd[TIMER_W-1:0]) - 1'b1);

    assert_timer_reload_R2: assert property (@(posedge clk) disable iff (rst)
        timer_rd[TIMER_W-1:0] == '0 |=> timer_rd[TIMER_W-1:0] == RELOAD && ref_req);

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        timer_rd[RD_W-1:TIMER_W] == '0);

    assert_cpu_cut_at_bnd_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(gnt_cpu) && $past(gnt_ibus) |-> $past(at_bnd));

    assert_no_preempt_fcfs_R10: assert property (@(posedge clk) disable iff (rst)
        policy_q && gnt_ibus && !ibus_done |=> gnt_ibus);
endmodule

bind mem_arb mem_arb_checker u_chk (.*);

// File: tb/mem_arb_tb.sv
module mem_arb_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pol_we = 0, pol_wd = 0, bnd_sel = 0;
    logic        cpu_req = 0, cpu_done = 0, ibus_req = 0, ibus_beat = 0, ibus_done = 0, ref_done = 0;
    logic        gnt_cpu, gnt_ref, gnt_ibus, ref_req;
    logic [31:0] timer_rd;
    int          cyc = 0;
    int          checks = 0, errors = 0;
    bit          finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

    mem_arb u_dut (
        .clk(clk), .rst(rst), .pol_we(pol_we), .pol_wd(pol_wd), .bnd_sel(bnd_sel),
        .cpu_req(cpu_req), .cpu_done(cpu_done), .ibus_req(ibus_req),
        .ibus_beat(ibus_beat), .ibus_done(ibus_done), .ref_done(ref_done),
        .gnt_cpu(gnt_cpu), .gnt_ref(gnt_ref), .gnt_ibus(gnt_ibus),
        .ref_req(ref_req), .timer_rd(timer_rd)
    );

    // {cycle after reset, expected timer, expected ref_req}
    localparam logic [32:0] TVEC [8] = '{
        {16'd0,   16'h0200, 1'b0},
        {16'd1,   16'h01FF, 1'b0},
        {16'd255, 16'h0101, 1'b0},
        {16'd511, 16'h0001, 1'b0},
        {16'd512, 16'h0000, 1'b0},
        {16'd513, 16'h0200, 1'b1},
        {16'd514, 16'h01FF, 1'b1},
        {16'd515, 16'h01FE, 1'b0}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [2:0] gv();
        return {gnt_ibus, gnt_ref, gnt_cpu};
    endfunction

    // count burst-granted cycles until the grant leaves the burst port
    task automatic count_ibus(output int n);
        n = 0;
        while (gnt_ibus && n < 200) begin
            n++;
            tick();
        end
    endtask

    initial begin
        int n;
        int g;
        repeat (3) @(posedge clk);
        tick();
        chk("R1", "grants in reset", {29'd0, gv()}, 32'd0);
        chk("R1", "timer in reset", timer_rd, 32'h0000_0200);
        chk("R1", "ref_req in reset", {31'd0, ref_req}, 32'd0);
        rst = 1'b0;

        // timer walk; refresh is served in cycle 514 so 515 shows it cleared
        for (int i = 0; i < 8; i++) begin
            while (cyc < int'(TVEC[i][32:17])) tick();
            chk("R2", "timer value", timer_rd, {16'd0, TVEC[i][16:1]});
            chk("R2", "ref_req", {31'd0, ref_req}, {31'd0, TVEC[i][0]});
            chk("R3", "upper timer bits", {16'd0, timer_rd[31:16]}, 32'd0);
            if (i == 0) chk("R1", "grants after reset", {29'd0, gv()}, 32'd0);
            if (i == 5) chk("R5", "refresh not yet granted", {29'd0, gv()}, 32'd0);
            if (i == 6) begin
                chk("R5", "idle refresh grant", {29'd0, gv()}, 32'b010);
                ref_done = 1'b1;
            end
            if (i == 7) begin
                ref_done = 1'b0;
                chk("R2", "grant released", {29'd0, gv()}, 32'd0);
            end
        end

        // R5: fixed priority from idle
        cpu_req = 1; ibus_req = 1;
        tick();
        chk("R5", "cpu wins over burst", {29'd0, gv()}, 32'b001);
        cpu_done = 1; cpu_req = 0;
        tick();
        cpu_done = 0;
        chk("R5", "gap cycle after done", {29'd0, gv()}, 32'd0);
        tick();
        chk("R5", "burst granted next", {29'd0, gv()}, 32'b100);

        // R6: CPU waits for the 16-word boundary
        bnd_sel = 0; ibus_beat = 1; cpu_req = 1;
        count_ibus(n);
        chk("R6", "burst cycles before cpu cut-in (16)", n, 32'd17);
        chk("R6", "cpu granted at boundary", {29'd0, gv()}, 32'b001);
        cpu_done = 1; cpu_req = 0;
        tick();
        cpu_done = 0; cpu_req = 1;
        chk("R8", "burst resumes after cpu", {29'd0, gv()}, 32'b100);
        count_ibus(n);
        chk("R8", "beat count kept across cut-in", n, 32'd16);
        cpu_done = 1; cpu_req = 0;
        tick();
        cpu_done = 0; ibus_beat = 0;
        ibus_done = 1; ibus_req = 0;
        tick();
        ibus_done = 0;
        chk("R4", "burst released", {29'd0, gv()}, 32'd0);

        // R6: 32-word boundary, fresh burst restarts the count
        bnd_sel = 1; ibus_req = 1;
        tick();
        chk("R6", "new burst granted", {29'd0, gv()}, 32'b100);
        ibus_beat = 1; cpu_req = 1;
        count_ibus(n);
        chk("R6", "burst cycles before cpu cut-in (32)", n, 32'd33);
        cpu_done = 1; cpu_req = 0;
        tick();
        cpu_done = 0; ibus_beat = 0;
        ibus_done = 1; ibus_req = 0;
        tick();
        ibus_done = 0;
        tick();

        // R7: refresh cuts into a burst at an arbitrary beat
        ibus_req = 1;
        tick();
        g = 0;
        while (!ref_req && g < 2000) begin g++; tick(); end
        chk("R7", "burst still owns when refresh rises", {29'd0, gv()}, 32'b100);
        tick();
        chk("R7", "refresh cut in", {29'd0, gv()}, 32'b010);
        ref_done = 1;
        tick();
        ref_done = 0;
        chk("R8", "burst resumes after refresh", {29'd0, gv()}, 32'b100);
        ibus_done = 1; ibus_req = 0;
        tick();
        ibus_done = 0;

        // R9: switch to arrival order
        pol_we = 1; pol_wd = 1;
        tick();
        pol_we = 0;
        tick();

        // R10: latency and arrival order beats fixed priority
        cpu_req = 1;
        tick();
        chk("R10", "no grant one cycle after arrival", {29'd0, gv()}, 32'd0);
        tick();
        chk("R10", "cpu granted two cycles after arrival", {29'd0, gv()}, 32'b001);
        ibus_req = 1;
        tick();
        cpu_done = 1; cpu_req = 0;
        tick();
        cpu_done = 0; cpu_req = 1;
        tick();
        chk("R9", "earlier burst beats later cpu", {29'd0, gv()}, 32'b100);
        bnd_sel = 0; ibus_beat = 1;
        n = 0;
        for (int k = 0; k < 40; k++) begin
            if (gnt_ibus) n++;
            tick();
        end
        chk("R10", "burst not preempted", n, 32'd40);
        ibus_beat = 0; ibus_done = 1; ibus_req = 0;
        tick();
        ibus_done = 0;
        chk("R10", "gap after burst", {29'd0, gv()}, 32'd0);
        tick();
        chk("R10", "queued cpu served", {29'd0, gv()}, 32'b001);
        cpu_done = 1; cpu_req = 0;
        tick();
        cpu_done = 0;

        // R11: three arrivals in one cycle
        g = 0;
        while (timer_rd[15:0] != 16'd0 && g < 2000) begin g++; tick(); end
        tick();
        chk("R11", "refresh pending", {31'd0, ref_req}, 32'd1);
        cpu_req = 1; ibus_req = 1;
        tick();
        tick();
        chk("R11", "cpu first on tie", {29'd0, gv()}, 32'b001);
        cpu_done = 1; cpu_req = 0;
        tick();
        cpu_done = 0;
        tick();
        chk("R11", "refresh second on tie", {29'd0, gv()}, 32'b010);
        ref_done = 1;
        tick();
        ref_done = 0;
        tick();
        chk("R11", "burst third on tie", {29'd0, gv()}, 32'b100);
        ibus_done = 1; ibus_req = 0;
        tick();
        ibus_done = 0;
        chk("R2", "refresh cleared after service", {31'd0, ref_req}, 32'd0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule